// File: doc/BRIEF.md
# Pixel Clock Synthesizer Coefficient Search

This engine finds the feedback, input and post-divide coefficients for a pixel clock synthesizer whose output is the integer value `REF_KHZ * (n + 2) / (m + 2)`, shifted right by `k`. A target frequency in kHz is handed over with a one-cycle start pulse. The engine then walks every `(m, n)` pair with a shared multi-cycle restoring divider. For each quotient it weighs all `k` shifts at once and keeps the setting with the smallest absolute error.

When the walk ends, a one-cycle done pulse marks the chosen `m`, `n` and `k`. The packed control word and the frequency that setting produces are valid at the same time and stay put until the next accepted start. A target above the supported maximum is refused straight away with an unsupported flag, and no walk is made.

The default coefficient ranges are 6 bits for `m`, 8 bits for `n` and 2 bits for `k`, with a 14318 kHz reference and a 270000 kHz ceiling. All of them are parameters.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, busy_o, done_o and unsup_o are 0, and m_o, n_o, k_o, ctrl_word_o and freq_khz_o are all 0.
- R2: The reported freq_khz_o equals (REF_KHZ*(n_o+2)/(m_o+2)) >> k_o, where the division is an integer division that drops the remainder.
- R3: ctrl_word_o is the concatenation {n_o, m_o, k_o}, with k in the least significant bits. With the default widths this is (n<<8)|(m<<2)|k.
- R4: The chosen setting has the minimum |f - target| over every m, n and k. The running best error starts at the target value. A candidate replaces it only if its error is strictly smaller, and candidates are visited with m outermost, n next and k innermost, so among equal errors the earliest one in that order wins.
- R5: If no candidate error is strictly below the target value (for example a target of 0), m_o, n_o, k_o, ctrl_word_o and freq_khz_o are all reported as 0.
- R6: A target greater than MAX_KHZ produces done_o in the cycle after the start, with unsup_o = 1 and all coefficient and frequency outputs 0. busy_o never rises for such a target. A target equal to MAX_KHZ is searched normally, with unsup_o = 0.
- R7: done_o is high for exactly one cycle per accepted start. Once it has risen, all result outputs and unsup_o hold their values until the next accepted start.
- R8: busy_o is high from the cycle after a supported start until done_o rises, with no gap. A start_i pulse seen while busy_o is high is ignored and does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only while idle |
| target_khz_i | input | FREQ_W | Target frequency in kHz, latched on an accepted start |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| unsup_o | output | 1 | Last target exceeded MAX_KHZ |
| m_o | output | M_BITS | Chosen input divider coefficient |
| n_o | output | N_BITS | Chosen feedback coefficient |
| k_o | output | K_BITS | Chosen post-divide shift |
| ctrl_word_o | output | N_BITS+M_BITS+K_BITS | Packed control word {n, m, k} |
| freq_khz_o | output | clog2(REF_KHZ*(2^N_BITS+1)+1) | Frequency produced by the chosen setting |

## Verification
The assertions assume that start_i is a clean synchronous level, and that the m and n counters are never cleared and stepped in the same cycle. The divider's quotient and remainder check also relies on a denominator that is never zero, which holds because it is always m+2. The stimulus drives start_i for exactly one cycle at a falling edge and always waits for done_o before it issues the next real target. The only exception is a deliberate second pulse while busy, which exercises the ignore rule. The bench uses narrowed coefficient widths, so that an exhaustive walk stays within a few thousand cycles while the reference, the ceiling and the ordering rules keep their default meaning.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_DIV  = 2'd2,
    ST_FIN  = 2'd3
  } srch_state_e;
endpackage

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
  parameter int NUM_W = 22,
  parameter int DEN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             valid_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num_q, quo_q, quo_n;
  logic [DEN_W-1:0] den_q, rem_q, rem_n;
  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;
  logic [DEN_W:0]   shifted, diff;

  // one restoring step: bring down next dividend bit, try subtract
  always_comb begin
    shifted = {rem_q, quo_q[NUM_W-1]};
    diff    = shifted - {1'b0, den_q};
    if (!diff[DEN_W]) begin
      rem_n = diff[DEN_W-1:0];
      quo_n = {quo_q[NUM_W-2:0], 1'b1};
    end else begin
      rem_n = shifted[DEN_W-1:0];
      quo_n = {quo_q[NUM_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q   <= '0;
      den_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      num_q   <= num_i;
      den_q   <= den_i;
      quo_q   <= num_i;
      rem_q   <= '0;
      cnt_q   <= CNT_W'(NUM_W);
      valid_q <= 1'b0;
    end else if (cnt_q != '0) begin
      quo_q   <= quo_n;
      rem_q   <= rem_n;
      cnt_q   <= cnt_q - 1'b1;
      valid_q <= (cnt_q == CNT_W'(1));
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign quo_o   = quo_q;

  logic [NUM_W+DEN_W-1:0] chk_prod;
  assign chk_prod = {{DEN_W{1'b0}}, quo_q} * {{NUM_W{1'b0}}, den_q}
                  + {{NUM_W{1'b0}}, rem_q};

  AST_DIV_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (chk_prod == {{DEN_W{1'b0}}, num_q}) && (rem_q < den_q)); // R2
endmodule

// File: rtl/pll_cand_cnt.sv
module pll_cand_cnt #(
  parameter int M_BITS = 6,
  parameter int N_BITS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [M_BITS-1:0] m_o,
  output logic [N_BITS-1:0] n_o,
  output logic              last_o
);
  logic [M_BITS-1:0] m_q;
  logic [N_BITS-1:0] n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= '0;
      n_q <= '0;
    end else if (clear_i) begin
      m_q <= '0;
      n_q <= '0;
    end else if (step_i) begin
      if (&n_q) begin
        n_q <= '0;
        m_q <= m_q + 1'b1;
      end else begin
        n_q <= n_q + 1'b1;
      end
    end
  end

  assign m_o    = m_q;
  assign n_o    = n_q;
  assign last_o = (&m_q) & (&n_q);

  // n is the inner index: m only moves when n wraps
  AST_N_INNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && !(&n_q)) |=> (m_q == $past(m_q))); // R4
endmodule

// File: rtl/pll_best_track.sv
module pll_best_track #(
  parameter int M_BITS = 6,
  parameter int N_BITS = 8,
  parameter int K_BITS = 2,
  parameter int Q_W    = 22,
  parameter int ERR_W  = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [ERR_W-1:0]  init_err_i,
  input  logic              upd_i,
  input  logic [Q_W-1:0]    quo_i,
  input  logic [ERR_W-1:0]  target_i,
  input  logic [M_BITS-1:0] m_i,
  input  logic [N_BITS-1:0] n_i,
  output logic [M_BITS-1:0] best_m_o,
  output logic [N_BITS-1:0] best_n_o,
  output logic [K_BITS-1:0] best_k_o,
  output logic [Q_W-1:0]    best_f_o
);
  localparam int K_NUM = 1 << K_BITS;

  logic [ERR_W-1:0]  err_q;
  logic [M_BITS-1:0] m_q;
  logic [N_BITS-1:0] n_q;
  logic [K_BITS-1:0] k_q;
  logic [Q_W-1:0]    f_q;

  logic [ERR_W-1:0]  ch_err [K_NUM+1];
  logic [K_BITS-1:0] ch_k   [K_NUM+1];
  logic [Q_W-1:0]    ch_f   [K_NUM+1];
  logic              ch_hit [K_NUM+1];

  assign ch_err[0] = err_q;
  assign ch_k[0]   = k_q;
  assign ch_f[0]   = f_q;
  assign ch_hit[0] = 1'b0;

  // k candidates compared in visiting order; strict less keeps the earlier
  for (genvar g = 0; g < K_NUM; g++) begin : g_k
    logic [Q_W-1:0]   f_g;
    logic [ERR_W-1:0] fe_g, e_g;
    logic             take_g;
    assign f_g    = quo_i >> g;
    assign fe_g   = ERR_W'(f_g);
    assign e_g    = (fe_g >= target_i) ? (fe_g - target_i) : (target_i - fe_g);
    assign take_g = (e_g < ch_err[g]);
    assign ch_err[g+1] = take_g ? e_g : ch_err[g];
    assign ch_k[g+1]   = take_g ? K_BITS'(g) : ch_k[g];
    assign ch_f[g+1]   = take_g ? f_g : ch_f[g];
    assign ch_hit[g+1] = take_g | ch_hit[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
      m_q   <= '0;
      n_q   <= '0;
      k_q   <= '0;
      f_q   <= '0;
    end else if (clear_i) begin
      err_q <= init_err_i;
      m_q   <= '0;
      n_q   <= '0;
      k_q   <= '0;
      f_q   <= '0;
    end else if (upd_i) begin
      err_q <= ch_err[K_NUM];
      if (ch_hit[K_NUM]) begin
        m_q <= m_i;
        n_q <= n_i;
        k_q <= ch_k[K_NUM];
        f_q <= ch_f[K_NUM];
      end
    end
  end

  assign best_m_o = m_q;
  assign best_n_o = n_q;
  assign best_k_o = k_q;
  assign best_f_o = f_q;

  AST_ERR_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clear_i) |=> (err_q <= $past(err_q))); // R4
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import pll_srch_pkg::*;
#(
  parameter int REF_KHZ = 14318,
  parameter int MAX_KHZ = 270000,
  parameter int FREQ_W  = 20,
  parameter int M_BITS  = 6,
  parameter int N_BITS  = 8,
  parameter int K_BITS  = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic [FREQ_W-1:0]                target_khz_i,
  output logic                             busy_o,
  output logic                             done_o,
  output logic                             unsup_o,
  output logic [M_BITS-1:0]                m_o,
  output logic [N_BITS-1:0]                n_o,
  output logic [K_BITS-1:0]                k_o,
  output logic [N_BITS+M_BITS+K_BITS-1:0]  ctrl_word_o,
  output logic [$clog2(REF_KHZ*((1<<N_BITS)+1)+1)-1:0] freq_khz_o
);
  localparam int NUM_MAX = REF_KHZ * ((1 << N_BITS) + 1);
  localparam int NUM_W   = $clog2(NUM_MAX + 1);
  localparam int DEN_W   = $clog2((1 << M_BITS) + 2);
  localparam int ERR_W   = ((NUM_W > FREQ_W) ? NUM_W : FREQ_W) + 1;

  srch_state_e       state_q, state_n;
  logic [FREQ_W-1:0] target_q;
  logic              unsup_q;

  logic              accept, over;
  logic              div_start, div_valid, step, last;
  logic [NUM_W-1:0]  num, quo;
  logic [DEN_W-1:0]  den;
  logic [M_BITS-1:0] cur_m, best_m;
  logic [N_BITS-1:0] cur_n, best_n;
  logic [K_BITS-1:0] best_k;
  logic [NUM_W-1:0]  best_f;

  assign accept    = start_i && (state_q == ST_IDLE);
  assign over      = ({1'b0, target_khz_i} > (FREQ_W+1)'(MAX_KHZ));
  assign div_start = (state_q == ST_LOAD);
  assign step      = (state_q == ST_DIV) && div_valid;
  assign num       = NUM_W'(REF_KHZ * (int'(cur_n) + 2));
  assign den       = DEN_W'(int'(cur_m) + 2);

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_n = over ? ST_FIN : ST_LOAD;
      ST_LOAD: state_n = ST_DIV;
      ST_DIV:  if (div_valid) state_n = last ? ST_FIN : ST_LOAD;
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
      unsup_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      if (accept) begin
        target_q <= target_khz_i;
        unsup_q  <= over;
      end
    end
  end

  pll_cand_cnt #(.M_BITS(M_BITS), .N_BITS(N_BITS)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .step_i  (step),
    .m_o     (cur_m),
    .n_o     (cur_n),
    .last_o  (last)
  );

  pll_div_seq #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (num),
    .den_i   (den),
    .valid_o (div_valid),
    .quo_o   (quo)
  );

  pll_best_track #(
    .M_BITS(M_BITS), .N_BITS(N_BITS), .K_BITS(K_BITS),
    .Q_W(NUM_W), .ERR_W(ERR_W)
  ) u_best (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .init_err_i (ERR_W'(target_khz_i)),
    .upd_i      (step),
    .quo_i      (quo),
    .target_i   (ERR_W'(target_q)),
    .m_i        (cur_m),
    .n_i        (cur_n),
    .best_m_o   (best_m),
    .best_n_o   (best_n),
    .best_k_o   (best_k),
    .best_f_o   (best_f)
  );

  assign busy_o      = (state_q == ST_LOAD) || (state_q == ST_DIV);
  assign done_o      = (state_q == ST_FIN);
  assign unsup_o     = unsup_q;
  assign m_o         = best_m;
  assign n_o         = best_n;
  assign k_o         = best_k;
  assign ctrl_word_o = {best_n, best_m, best_k};
  assign freq_khz_o  = best_f;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(ctrl_word_o) && $stable(freq_khz_o) && $stable(unsup_o))); // R7
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(target_q)); // R8
  AST_UNSUP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |-> (ctrl_word_o == '0) && (freq_khz_o == '0)); // R6
endmodule

// File: tb/pll_coef_search_tb_top.sv
module pll_coef_search_tb_top;
  localparam int REF_KHZ = 14318;
  localparam int MAX_KHZ = 270000;
  localparam int FREQ_W  = 20;
  localparam int M_BITS  = 3;
  localparam int N_BITS  = 4;
  localparam int K_BITS  = 2;
  localparam int MMAX    = (1 << M_BITS) - 1;
  localparam int NMAX    = (1 << N_BITS) - 1;
  localparam int KMAX    = (1 << K_BITS) - 1;
  localparam int FO_W    = $clog2(REF_KHZ * ((1 << N_BITS) + 1) + 1);
  localparam int CW_W    = N_BITS + M_BITS + K_BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [FREQ_W-1:0] target = '0;
  logic busy, done, unsup;
  logic [M_BITS-1:0] m_out;
  logic [N_BITS-1:0] n_out;
  logic [K_BITS-1:0] k_out;
  logic [CW_W-1:0]   word;
  logic [FO_W-1:0]   freq;

  always #2 clk = ~clk;

  pll_coef_search #(
    .REF_KHZ(REF_KHZ), .MAX_KHZ(MAX_KHZ), .FREQ_W(FREQ_W),
    .M_BITS(M_BITS), .N_BITS(N_BITS), .K_BITS(K_BITS)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .target_khz_i(target),
    .busy_o(busy), .done_o(done), .unsup_o(unsup),
    .m_o(m_out), .n_o(n_out), .k_o(k_out),
    .ctrl_word_o(word), .freq_khz_o(freq)
  );

  typedef struct {
    int m; int n; int k; int f; bit unsup;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // reference model built from R2, R4, R5, R6
  function automatic exp_t model(input int tgt);
    exp_t r;
    int best;
    r = '{m: 0, n: 0, k: 0, f: 0, unsup: 1'b0};
    if (tgt > MAX_KHZ) begin
      r.unsup = 1'b1;
      return r;
    end
    best = tgt;
    for (int mi = 0; mi <= MMAX; mi++)
      for (int ni = 0; ni <= NMAX; ni++)
        for (int ki = 0; ki <= KMAX; ki++) begin
          int f, e;
          f = (REF_KHZ * (ni + 2) / (mi + 2)) >> ki;
          e = (f > tgt) ? f - tgt : tgt - f;
          if (e < best) begin
            best = e;
            r.m = mi; r.n = ni; r.k = ki; r.f = f;
          end
        end
    return r;
  endfunction

  // monitor: pop expected on every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        int w;
        e = exp_q.pop_front();
        w = (e.n << (M_BITS + K_BITS)) | (e.m << K_BITS) | e.k;
        check(int'(m_out) == e.m, "R4 m", m_out, e.m);
        check(int'(n_out) == e.n, "R4 n", n_out, e.n);
        check(int'(k_out) == e.k, "R4 k", k_out, e.k);
        check(int'(freq) == e.f, "R2 freq", freq, e.f);
        check(int'(word) == w, "R3 ctrl word", word, w);
        check(unsup == e.unsup, "R6 unsup", unsup, e.unsup);
        if (e.f == 0 && !e.unsup)
          check(word == '0 && freq == '0, "R5 zero result", word, 0);
      end
    end
  end

  task automatic wait_done(input bit supported);
    int gaps = 0;
    while (!done) begin
      if (!busy) gaps++;
      @(negedge clk);
    end
    if (supported) check(gaps == 0, "R8 busy gap", gaps, 0);
    else check(busy == 1'b0, "R6 busy on reject", busy, 0);
  endtask

  task automatic hold_check();
    logic [CW_W-1:0] w0;
    logic [FO_W-1:0] f0;
    logic u0;
    w0 = word; f0 = freq; u0 = unsup;
    @(negedge clk);
    check(done == 1'b0, "R7 done width", done, 0);
    repeat (6) @(negedge clk);
    check(word == w0 && freq == f0 && unsup == u0, "R7 hold", word, w0);
  endtask

  task automatic run_search(input int tgt);
    bit sup;
    sup = (tgt <= MAX_KHZ);
    exp_q.push_back(model(tgt));
    @(negedge clk);
    start = 1'b1;
    target = FREQ_W'(tgt);
    @(negedge clk);
    start = 1'b0;
    target = '0;
    check(busy == sup, "R8 busy after start", busy, sup);
    wait_done(sup);
    hold_check();
  endtask

  task automatic run_restart(input int tgt_a, input int tgt_b);
    exp_q.push_back(model(tgt_a));
    @(negedge clk);
    start = 1'b1;
    target = FREQ_W'(tgt_a);
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    check(busy == 1'b1, "R8 busy mid search", busy, 1);
    start = 1'b1;
    target = FREQ_W'(tgt_b);
    @(negedge clk);
    start = 1'b0;
    target = '0;
    wait_done(1'b1);
    hold_check();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !unsup, "R1 reset flags", {busy, done, unsup}, 0);
    check(word == '0 && freq == '0 && m_out == '0 && n_out == '0 && k_out == '0,
          "R1 reset outputs", word, 0);

    run_search(65000);     // R2 R3 R4
    run_search(14318);     // R4 tie: earliest exact match
    run_search(0);         // R5
    run_search(100);       // R5 nothing beats initial error
    run_search(3000);      // R4 uses k shift
    run_search(25175);
    run_search(40000);
    run_search(121703);    // max reachable frequency
    run_search(270000);    // R6 boundary, searched
    run_search(270001);    // R6 rejected
    run_search(1000000);   // R6 rejected
    run_search(108000);    // clears unsup after reject
    run_restart(31500, 5000); // R8 start while busy ignored

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R7 missing done", exp_q.size(), 0);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
  end
endmodule